// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge-Triggered Interrupt

This block is a byte-wide, register-mapped general-purpose I/O port. It serves eight pins whose direction is fixed in hardware. Pins 0 to 3 are driven outputs and pins 4 to 7 are sampled inputs. A host reaches the port over a simple synchronous bus with an address, a read strobe, a write strobe and separate write and read data buses. It uses the port to drive the output pins, sample the input pins and receive an interrupt when a chosen edge appears on an input.

Each input is first passed through a two-flop synchroniser. A one-cycle edge pulse is then taken by comparing the synchronised value with the value one cycle older. Every input has its own two-bit edge selector, which picks no edge, falling edges, rising edges or both. A qualifying edge sets a sticky pending bit. The host clears a pending bit by writing a one to it, usually by writing back the value it has just read. The level interrupt line is high while any pending bit is set.

A direction register is kept for host compatibility. It stores and returns whatever the host writes, but it has no effect on the pins. Offset 2 and offsets 5 to 7 are holes in the map.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the output pins, the direction register, the edge-select register and every pending bit are 0, and `irq` is low.
- R2: A write to offset 1 drives `pin_out` from `bus_wdata[3:0]` from the next clock edge and ignores `bus_wdata[7:4]`. `pin_out` changes on no other access.
- R3: A read of offset 1 returns `{synchronised pin_in[3:0], pin_out[3:0]}`. A change on `pin_in` becomes visible there two clock edges after it is applied.
- R4: Offset 0 stores all 8 written bits and reads them back. Writing it never changes `pin_out` or which pins are inputs.
- R5: Offset 3 is the edge-select register. It is read/write and holds 2 bits per input: input k uses bits [2k+1:2k]. Bit 2k enables falling edges and bit 2k+1 enables rising edges. A pair of 00 blocks both edges, and writing 0 to the register stops all new events.
- R6: At offset 4, pending bit k is set by an enabled edge on input k (pin 4+k). It is visible on the third clock edge after the input changes. A disabled edge leaves it clear.
- R7: A write to offset 4 clears every pending bit whose written bit is 1 and leaves the bits written with 0 unchanged. Written bits 7:4 have no effect.
- R8: If an enabled edge on input k arrives in the same cycle as a write that clears pending bit k, the bit stays set.
- R9: `irq` is high exactly while at least one pending bit is set. It falls only after a write to offset 4.
- R10: Reads of offsets 2, 5, 6 and 7 return 0 and writes to them change no state. Bits 7:4 of offset 4 always read 0.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; taken at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| pin_in | input | 4 | Asynchronous input pins 4 to 7 |
| pin_out | output | 4 | Output pins 0 to 3 |
| irq | output | 1 | Level interrupt request |

## Verification
The bench gives each input lane a different selector value and applies both edge directions. It then checks that only the enabled edges set pending bits. A design with the falling and rising bits of a pair swapped would show the wrong bits set. So would a design that decodes the pairs at the wrong offset.

A partial clear checks that only the bits written as one are cleared. A write of one to the upper nibble checks that those bits clear nothing. A design that clears the whole register, or that treats the write as a plain store, would leave the wrong pending set behind.

One test times a clear so that it lands in the same cycle as a new edge on the same input. A design that lets the clear take priority would lose that event and drop `irq`. The bench also reads the map holes and the direction register. This exposes an address decoder that aliases those offsets onto live registers, and a direction value that leaks onto the pins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register offsets seen by host software; these values are fixed.
    localparam logic [2:0] OFS_DIR  = 3'd0;
    localparam logic [2:0] OFS_DATA = 3'd1;
    localparam logic [2:0] OFS_CFG  = 3'd3;
    localparam logic [2:0] OFS_STAT = 3'd4;

    // Bit positions inside each per-input edge-select pair.
    localparam int SEL_FALL = 0;
    localparam int SEL_RISE = 1;
    localparam int SEL_W    = 2;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.sync;

    for (genvar k = 0; k < N; k++) begin : g_edge
        assign rise_o[k] =  s_q.sync[k] & ~s_q.prev[k];
        assign fall_o[k] = ~s_q.sync[k] &  s_q.prev[k];
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_edge_pkg::*;
#(
    parameter int N = 4,
    localparam int CFG_W = SEL_W * N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             stat_wr,
    input  logic [N-1:0]     stat_wdata,
    input  logic [N-1:0]     rise_i,
    input  logic [N-1:0]     fall_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [N-1:0]     stat_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [N-1:0]     stat;
    } irq_t;

    irq_t         r_d, r_q;
    logic [N-1:0] hit;
    logic [N-1:0] clr;

    for (genvar k = 0; k < N; k++) begin : g_hit
        assign hit[k] = (rise_i[k] & r_q.cfg[SEL_W*k + SEL_RISE])
                      | (fall_i[k] & r_q.cfg[SEL_W*k + SEL_FALL]);
    end

    assign clr = stat_wr ? stat_wdata : '0;

    always_comb begin
        r_d = r_q;
        if (cfg_wr) r_d.cfg = cfg_wdata;
        // a fresh event outranks a clear landing in the same cycle
        r_d.stat = (r_q.stat & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o  = r_q.cfg;
    assign stat_o = r_q.stat;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int N_OUT  = 4,
    parameter int N_IN   = 4,
    parameter int ADDR_W = 3,
    localparam int PIN_W = N_OUT + N_IN,
    localparam int CFG_W = SEL_W * N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_OUT-1:0]  pin_out,
    output logic              irq
);

    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [N_OUT-1:0] dout;
    } port_t;

    port_t             p_d, p_q;
    logic [N_IN-1:0]   in_lvl, in_rise, in_fall;
    logic [CFG_W-1:0]  cfg_q;
    logic [N_IN-1:0]   stat_q;
    logic              hit_dir, hit_data, hit_cfg, hit_stat;

    assign hit_dir  = (bus_addr == ADDR_W'(OFS_DIR));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));

    gpio_in_sync #(.N(N_IN)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .level_o (in_lvl),
        .rise_o  (in_rise),
        .fall_o  (in_fall)
    );

    gpio_irq_status #(.N(N_IN)) stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (bus_wr & hit_cfg),
        .cfg_wdata  (bus_wdata[CFG_W-1:0]),
        .stat_wr    (bus_wr & hit_stat),
        .stat_wdata (bus_wdata[N_IN-1:0]),
        .rise_i     (in_rise),
        .fall_i     (in_fall),
        .cfg_o      (cfg_q),
        .stat_o     (stat_q)
    );

    always_comb begin
        p_d = p_q;
        if (bus_wr && hit_dir)  p_d.dir  = bus_wdata;
        if (bus_wr && hit_data) p_d.dout = bus_wdata[N_OUT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_dir)  bus_rdata = p_q.dir;
            if (hit_data) bus_rdata = {in_lvl, p_q.dout};
            if (hit_cfg)  bus_rdata[CFG_W-1:0] = cfg_q;
            if (hit_stat) bus_rdata[N_IN-1:0]  = stat_q;
        end
    end

    assign pin_out = p_q.dout;
    assign irq     = |stat_q;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
    import gpio_edge_pkg::*;
#(
    parameter int N_OUT  = 4,
    parameter int N_IN   = 4,
    parameter int ADDR_W = 3,
    localparam int PIN_W = N_OUT + N_IN,
    localparam int CFG_W = SEL_W * N_IN
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [N_OUT-1:0]  pin_out,
    input logic              irq,
    input logic [CFG_W-1:0]  cfg
);

    logic wr_data, wr_stat, map_hole;
    assign wr_data  = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign map_hole = !(bus_addr == ADDR_W'(OFS_DIR)  || bus_addr == ADDR_W'(OFS_DATA) ||
                        bus_addr == ADDR_W'(OFS_CFG)  || bus_addr == ADDR_W'(OFS_STAT));

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (pin_out == '0 && irq == 1'b0);
        end
    end

    // R2
    dout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> pin_out == $past(bus_wdata[N_OUT-1:0]));

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(pin_out));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    // R10
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && map_hole) |-> bus_rdata == '0);

    // R10
    stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_STAT)) |-> bus_rdata[PIN_W-1:N_IN] == '0);

    // R6
    irq_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg) != '0);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_stat));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .N_OUT  (N_OUT),
    .N_IN   (N_IN),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .cfg       (cfg_q)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb_top;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    gpio_edge_irq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: compares read data a quarter period after the driving edge
    always @(negedge clk) begin
        #(PERIOD/4);
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: unexpected read got 0x%02h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pin_out", {4'h0, pin_out}, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
        rd(3'd0, 8'h00, "R1 dir");
        rd(3'd3, 8'h00, "R1 cfg");
        rd(3'd4, 8'h00, "R1 stat");

        // R2 output write, upper bits dropped; R3 read of pins
        wr(3'd1, 8'hA5);
        check("R2 pin_out", {4'h0, pin_out}, 8'h05);
        rd(3'd1, 8'h05, "R3 data low inputs");

        // R4 direction register stored, no effect on pins
        wr(3'd0, 8'h0F);
        rd(3'd0, 8'h0F, "R4 dir readback");
        wr(3'd0, 8'h3C);
        rd(3'd0, 8'h3C, "R4 dir readback 2");
        check("R4 pin_out untouched", {4'h0, pin_out}, 8'h05);

        // R5 all lanes masked: edges produce no event; R3 inputs visible
        set_pins(4'hF);
        idle(1);
        rd(3'd1, 8'hF5, "R3 data after two edges");
        idle(2);
        rd(3'd4, 8'h00, "R5 masked rise");
        set_pins(4'h0);
        idle(3);
        rd(3'd4, 8'h00, "R5 masked fall");
        check("R9 irq idle", {7'h0, irq}, 8'h00);

        // R5 lane0 rise, lane1 fall, lane2 both, lane3 off -> 0x36
        wr(3'd3, 8'h36);
        rd(3'd3, 8'h36, "R5 cfg readback");
        set_pins(4'hF);
        idle(2);
        rd(3'd4, 8'h05, "R6 rise selects");
        check("R9 irq set", {7'h0, irq}, 8'h01);
        wr(3'd4, 8'h05);
        rd(3'd4, 8'h00, "R7 full clear");
        check("R9 irq cleared", {7'h0, irq}, 8'h00);

        set_pins(4'h0);
        idle(2);
        rd(3'd4, 8'h06, "R6 fall selects");
        wr(3'd4, 8'h02);
        rd(3'd4, 8'h04, "R7 partial clear");
        wr(3'd4, 8'hF0);
        rd(3'd4, 8'h04, "R7 upper bits no clear");
        wr(3'd4, 8'h04);
        rd(3'd4, 8'h00, "R7 last clear");

        // R8 edge wins against a clear in the same cycle
        set_pins(4'h4);
        idle(2);
        rd(3'd4, 8'h04, "R8 setup");
        set_pins(4'h0);
        idle(1);
        wr(3'd4, 8'h04);
        rd(3'd4, 8'h04, "R8 edge beats clear");
        check("R8 irq held", {7'h0, irq}, 8'h01);
        wr(3'd4, 8'h04);
        rd(3'd4, 8'h00, "R8 later clear");

        // R10 holes read zero and writes are dropped
        wr(3'd2, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd2, 8'h00, "R10 hole 2");
        rd(3'd5, 8'h00, "R10 hole 5");
        rd(3'd7, 8'h00, "R10 hole 7");
        rd(3'd0, 8'h3C, "R10 dir kept");
        rd(3'd3, 8'h36, "R10 cfg kept");
        rd(3'd4, 8'h00, "R10 stat kept");
        check("R10 pin_out kept", {4'h0, pin_out}, 8'h05);

        // R11 no read strobe -> zero
        @(negedge clk);
        bus_addr = 3'd0;
        #(PERIOD/4);
        check("R11 idle rdata", bus_rdata, 8'h00);

        // R5 writing zero stops new events
        wr(3'd3, 8'h00);
        set_pins(4'hF);
        idle(3);
        rd(3'd4, 8'h00, "R5 zero cfg");
        check("R9 irq stays low", {7'h0, irq}, 8'h00);

        idle(3);
        report();
    end

endmodule